// File: doc/BRIEF.md
# Per-Channel Power-Down Sequencer

This block sits in the digital back end of a multichannel sampling converter and governs when each channel is switched off and when its output data may be trusted again. Each channel has its own active-low power-down request pin. The pin passes through a two-flop synchronizer onto the master clock. A small state machine for each channel then qualifies the pin: a low level must be seen on two consecutive clocks before the channel is taken down, so a single-clock dip is rejected.

When the request returns high, the channel counts conversion periods, which arrive as one-clock pulses on `conv_tick`. It reports its data as valid only once the settle count is reached. That count is 130 for the serial-peripheral readout protocol and 129 for the frame-sync protocol. The protocol is chosen by `mode_fsync`, and the block captures that pin only while reset is asserted. The block also drives the active-low data-ready/frame-sync strobe. This strobe follows the conversion pulse and is held high when every channel is down.

Each channel steps through five named states:

- RUN: powered and valid.
- RUN_QUAL: a low request has been seen once. The channel is still valid.
- DOWN: powered down.
- SETTLE: released and counting conversion periods.
- SETTLE_QUAL: a low request has been seen once while settling. Counting continues.

The transitions are:

- RUN goes to RUN_QUAL on a low request.
- RUN_QUAL goes to DOWN on a second low, or back to RUN on a high.
- DOWN goes to SETTLE on a high, and the count restarts from zero.
- SETTLE goes to RUN when the count reaches the limit, or to SETTLE_QUAL on a low request.
- SETTLE_QUAL goes to DOWN on a second low. On a high it goes to SETTLE, or to RUN if the count has reached the limit.

Top module: `pwdn_sequencer`

## Requirements
- R1: A channel whose `pd_n` bit is held low for two or more consecutive clock cycles goes down, and its `ch_valid` bit becomes 0.
- R2: A low pulse of exactly one clock cycle on a `pd_n` bit is ignored, and that channel's `ch_valid` stays 1.
- R3: With `mode_fsync`=0 captured at reset, a released channel's `ch_valid` bit is 0 after 129 `conv_tick` pulses and 1 after the 130th.
- R4: With `mode_fsync`=1 captured at reset, a released channel's `ch_valid` bit is 0 after 128 pulses and 1 after the 129th.
- R5: `mode_fsync` is sampled only while `rst_n` is low. Changing it after reset does not change the settle count.
- R6: Channels that are running keep `ch_valid`=1 while other channels go down or settle.
- R7: `all_down` is 1 exactly when every channel is down. While it is 1, `drdy_n` stays 1 even during `conv_tick`. Otherwise `drdy_n` equals the inverse of `conv_tick`.
- R8: Channels released in the same cycle become valid on the same `conv_tick`.
- R9: After reset every channel is running and valid, and `all_down` is 0.
- R10: A channel taken down again while it is settling restarts its full settle count on its next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset; `mode_fsync` is captured while low |
| mode_fsync | input | 1 | Protocol select: 0 serial-peripheral (130), 1 frame-sync (129) |
| pd_n | input | NCH | Active-low power-down request, one bit per channel, asynchronous |
| conv_tick | input | 1 | One-clock pulse per conversion period |
| ch_valid | output | NCH | Channel powered and settled |
| all_down | output | 1 | Every channel is powered down |
| drdy_n | output | 1 | Active-low data-ready/frame-sync strobe |

## Verification
The hardest case to reach from the ports is a channel caught between states: a power-down request that lands while the channel is still settling, followed by a release that must restart the full count. Reaching it also means counting exactly one period short of the limit. The stimulus reaches it with a directed sequence: release a channel, deliver part of the settle count, pull it low again for two clocks, release it, and count the full limit from zero. Random pulse widths of one to three clocks on random channels then mix rejected glitches with real power cycles. Each random step checks the other channels' valid bits.

// File: rtl/pwdn_pkg.sv
package pwdn_pkg;
    typedef enum logic [2:0] {
        CH_RUN         = 3'd0,
        CH_RUN_QUAL    = 3'd1,
        CH_DOWN        = 3'd2,
        CH_SETTLE      = 3'd3,
        CH_SETTLE_QUAL = 3'd4
    } ch_state_t;
endpackage

// File: rtl/pwdn_sync.sv
module pwdn_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end
endmodule

// File: rtl/pwdn_channel.sv
module pwdn_channel
    import pwdn_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_hi,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          valid,
    output logic          is_down
);
    ch_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = (tick && cnt_q < limit) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_RUN: begin
                if (!req_hi) state_d = CH_RUN_QUAL;
            end
            CH_RUN_QUAL: begin
                state_d = req_hi ? CH_RUN : CH_DOWN;
            end
            CH_DOWN: begin
                if (req_hi) begin
                    state_d = CH_SETTLE;
                    cnt_d   = '0;
                end
            end
            CH_SETTLE: begin
                cnt_d = cnt_inc;
                if (!req_hi)              state_d = CH_SETTLE_QUAL;
                else if (cnt_inc == limit) state_d = CH_RUN;
            end
            CH_SETTLE_QUAL: begin
                cnt_d = cnt_inc;
                if (!req_hi)              state_d = CH_DOWN;
                else if (cnt_inc == limit) state_d = CH_RUN;
                else                       state_d = CH_SETTLE;
            end
            default: state_d = CH_RUN;
        endcase
    end

    always_comb begin
        valid   = (state_q == CH_RUN) || (state_q == CH_RUN_QUAL);
        is_down = (state_q == CH_DOWN);
    end

    // R1: a channel reaches DOWN only through a qualification state
    p_down_needs_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DOWN && $past(state_q) != CH_DOWN) |->
        ($past(state_q) == CH_RUN_QUAL || $past(state_q) == CH_SETTLE_QUAL));

    // R2: one high request during qualification returns to RUN
    p_glitch_rejected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN_QUAL && req_hi) |=> (state_q == CH_RUN));

    // R3: the settle counter never exceeds its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SETTLE || state_q == CH_SETTLE_QUAL) |-> (cnt_q <= limit));

    // R4: leaving the settle states into RUN requires a full count
    p_valid_after_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && ($past(state_q) == CH_SETTLE ||
         $past(state_q) == CH_SETTLE_QUAL)) |-> (cnt_q == limit));

    // R10: a release from DOWN starts counting from zero
    p_release_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DOWN && req_hi) |=> (state_q == CH_SETTLE && cnt_q == '0));
endmodule

// File: rtl/pwdn_sequencer.sv
module pwdn_sequencer #(
    parameter int NCH        = 4,
    parameter int SPI_SETTLE = 130,
    parameter int FS_SETTLE  = 129
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_fsync,
    input  logic [NCH-1:0] pd_n,
    input  logic           conv_tick,
    output logic [NCH-1:0] ch_valid,
    output logic           all_down,
    output logic           drdy_n
);
    localparam int MAXS = (SPI_SETTLE > FS_SETTLE) ? SPI_SETTLE : FS_SETTLE;
    localparam int CW   = $clog2(MAXS + 1);
    localparam logic [CW-1:0] LIM_SPI = CW'(SPI_SETTLE);
    localparam logic [CW-1:0] LIM_FS  = CW'(FS_SETTLE);

    logic           mode_q;
    logic [CW-1:0]  limit;
    logic [NCH-1:0] req_sync;
    logic [NCH-1:0] down_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_fsync;
    end

    assign limit = mode_q ? LIM_FS : LIM_SPI;

    pwdn_sync #(.W(NCH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pd_n),
        .sync_out (req_sync)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwdn_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (req_sync[c]),
            .tick    (conv_tick),
            .limit   (limit),
            .valid   (ch_valid[c]),
            .is_down (down_vec[c])
        );
    end

    assign all_down = &down_vec;
    assign drdy_n   = all_down | ~conv_tick;

    // R7: no data-ready strobe while every channel is down
    p_quiet_when_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_down |-> drdy_n);

    // R5: the captured protocol mode holds outside reset
    p_mode_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q) || !$past(rst_n));

    // R6: a channel in DOWN is never reported valid
    p_down_not_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid & down_vec) == '0);
endmodule

// File: tb/pwdn_sequencer_test.sv
module pwdn_sequencer_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_fsync = 1'b0;
    logic [NCH-1:0] pd_n = '1;
    logic           conv_tick = 1'b0;
    logic [NCH-1:0] ch_valid;
    logic           all_down;
    logic           drdy_n;

    int checks = 0;
    int errors = 0;
    logic [NCH-1:0] exp_valid;
    int lim;

    always #10 clk = ~clk;

    pwdn_sequencer #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .mode_fsync(mode_fsync), .pd_n(pd_n),
        .conv_tick(conv_tick), .ch_valid(ch_valid), .all_down(all_down),
        .drdy_n(drdy_n)
    );

    function automatic int settle_for(input logic fs);
        return fs ? 129 : 130;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            conv_tick = 1'b1;
            @(negedge clk);
            conv_tick = 1'b0;
        end
    endtask

    task automatic do_reset(input logic fs);
        @(negedge clk);
        rst_n = 1'b0;
        mode_fsync = fs;
        pd_n = '1;
        wait_clk(3);
        rst_n = 1'b1;
        lim = settle_for(fs);
        exp_valid = '1;
        wait_clk(1);
    endtask

    task automatic pulse(input int ch, input int w);
        @(negedge clk);
        pd_n[ch] = 1'b0;
        wait_clk(w);
        pd_n[ch] = 1'b1;
        wait_clk(6);
    endtask

    task automatic settle_check(input string req, input logic [NCH-1:0] mask);
        do_ticks(lim - 1);
        check(req, int'(ch_valid & mask), 0);
        do_ticks(1);
        check(req, int'(ch_valid & mask), int'(mask));
    endtask

    initial begin
        do_reset(1'b0);
        // R9 reset state
        check("R9", int'(ch_valid), 'hF);
        check("R9", int'(all_down), 0);

        // R2 single-cycle glitch ignored
        pulse(1, 1);
        check("R2", int'(ch_valid), 'hF);

        // R1 two-cycle low takes the channel down, R6 others keep running
        @(negedge clk); pd_n[2] = 1'b0;
        wait_clk(6);
        check("R1", int'(ch_valid[2]), 0);
        check("R6", int'(ch_valid), 'hB);
        // R7 data-ready still follows the tick
        @(negedge clk); conv_tick = 1'b1; #1;
        check("R7", int'(drdy_n), 0);
        @(negedge clk); conv_tick = 1'b0;
        // R3 serial-peripheral settle of 130
        pd_n[2] = 1'b1;
        wait_clk(5);
        settle_check("R3", 4'b0100);
        check("R6", int'(ch_valid), 'hF);

        // R10 re-power-down during settle restarts the count
        pulse(0, 2);
        do_ticks(50);
        check("R10", int'(ch_valid[0]), 0);
        pulse(0, 2);
        settle_check("R10", 4'b0001);

        // R7 all channels down
        @(negedge clk); pd_n = '0;
        wait_clk(6);
        check("R7", int'(all_down), 1);
        check("R7", int'(ch_valid), 0);
        @(negedge clk); conv_tick = 1'b1; #1;
        check("R7", int'(drdy_n), 1);
        @(negedge clk); conv_tick = 1'b0;
        // R8 release two together
        pd_n[1] = 1'b1; pd_n[3] = 1'b1;
        wait_clk(5);
        check("R7", int'(all_down), 0);
        settle_check("R8", 4'b1010);
        pd_n = '1;
        wait_clk(5);
        do_ticks(lim);
        check("R8", int'(ch_valid), 'hF);

        // R4 frame-sync mode, R5 later change of the mode pin ignored
        do_reset(1'b1);
        mode_fsync = 1'b0;
        pulse(3, 3);
        check("R4", int'(ch_valid[3]), 0);
        settle_check("R4", 4'b1000);
        pulse(0, 2);
        do_ticks(129);
        check("R5", int'(ch_valid[0]), 1);

        // random mix, fixed seed
        do_reset(1'b0);
        void'($urandom(32'd1234));
        for (int it = 0; it < 24; it++) begin
            int ch;
            int w;
            ch = $urandom % NCH;
            w  = 1 + ($urandom % 3);
            pulse(ch, w);
            if (w >= 2) begin
                exp_valid[ch] = 1'b0;
                check(w >= 2 ? "R1" : "R2", int'(ch_valid), int'(exp_valid));
                settle_check("R3", 4'(1 << ch));
                exp_valid[ch] = 1'b1;
            end
            check("R6", int'(ch_valid), int'(exp_valid));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule